// File: doc/BRIEF.md
# Oversampling UART Receiver with Address Filtering

This block turns an asynchronous serial line into received words. Each frame is one low start bit, eight data bits sent least significant first, a ninth bit, and one high stop bit. A free-running sample tick clocks the receiver. A mode input sets how many ticks make up one bit: sixteen normally, or eight when the fast mode is on. In the normal rate the receiver takes three samples around the middle of each bit and keeps the majority value. In the fast rate it takes one sample at the centre of the bit.

The received byte and its ninth bit are held in a one-entry buffer. A ready flag shows when the buffer holds a word. A read pulse takes the word and clears the ready flag and the error flags. Two error flags are kept: a framing error when the stop bit is low, and an overrun when a new frame completes while the held word is still unread. In address mode, a frame whose ninth bit is 0 is a data frame, and it is dropped without any trace. Clearing the enable empties the buffer and its flags, and stops the receiver from using the line. The interrupt output is gated by a local enable and a global enable.

States of the receive sequencer: IDLE (waiting for a low line on a tick), START (checking the start bit), SHIFT (collecting the eight data bits and the ninth bit), STOP (checking the stop bit). Transitions: IDLE→START on a low sample; START→IDLE when the start bit votes high (false start); START→SHIFT at the end of the start bit; SHIFT→STOP at the end of the ninth bit; STOP→IDLE at the stop-bit decision point; any state→IDLE while disabled.

Top module: `uart_rx_mp`

## Requirements
- R1: After reset, rx_data, rx_bit9, rx_done, frame_err, overrun and irq are all 0.
- R2: A frame is received as a low start bit, then data bits d0 to d7 (least significant first), then the ninth bit, then a stop bit. When it completes, rx_data holds d7..d0, rx_bit9 holds the ninth bit and rx_done is 1.
- R3: With dbl_speed=1 a bit lasts 8 sample ticks, with a single sample at tick index 4 of the bit. With dbl_speed=0 a bit lasts 16 ticks.
- R4: With dbl_speed=0 each bit is the majority of the samples at tick indices 7, 8 and 9 of the bit. A single wrong sample at one of those indices does not change the received bit.
- R5: If the start bit votes high at its decision point, the receiver goes back to IDLE. No word is delivered, and the next frame is received normally.
- R6: A stop bit that votes low delivers the word and sets frame_err to 1.
- R7: When a frame completes while rx_done is 1 and no read is taking place, overrun becomes 1. rx_data, rx_bit9 and frame_err keep the old word's values.
- R8: With mp_mode=1, a frame whose ninth bit is 0 changes no output. This includes rx_done and overrun. A frame whose ninth bit is 1 is delivered.
- R9: A one-cycle rd_ack pulse clears rx_done, frame_err and overrun.
- R10: While rx_en=0, rx_data, rx_bit9, rx_done, frame_err and overrun read 0, and activity on rxd has no effect. Setting rx_en back to 1 makes the receiver work again.
- R11: irq equals rx_done AND rxc_ie AND glb_ie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; 0 flushes the buffer |
| dbl_speed | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| mp_mode | input | 1 | Address mode: drop frames whose ninth bit is 0 |
| rxc_ie | input | 1 | Local enable for the receive-done interrupt |
| glb_ie | input | 1 | Global interrupt enable |
| smp_tick | input | 1 | One-clock sample strobe at the oversampling rate |
| rxd | input | 1 | Serial input line, idle high |
| rd_ack | input | 1 | Read pulse; takes the held word |
| rx_data | output | 8 | Held data byte |
| rx_bit9 | output | 1 | Held ninth bit |
| rx_done | output | 1 | A word is waiting to be read |
| frame_err | output | 1 | Stop bit of the held word was low |
| overrun | output | 1 | A frame completed while the word was unread |
| irq | output | 1 | Gated receive interrupt |

## Verification
A wrong tick count or a wrong sample position in the sequencer shifts the sampled bits. This shows up as a wrong rx_data or rx_bit9 at the end of the first frame, about one frame time after the start edge. A sequencer stuck in a state, or one that misses a false start, shows rx_done missing or set wrongly. Wrong buffer state (a flag not cleared, a word overwritten, a dropped frame that still counts) shows on the flag outputs. A reference model compares those outputs on every clock, so such an error is seen in the cycle after the frame completes or the read pulse arrives.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_SHIFT,
        S_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_NORM = 16,
    parameter int OS_FAST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fast,
    input  logic              tick,
    input  logic              rx_s,
    output logic              frm_done,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_x,
    output logic              frm_stop_ok
);
    localparam int BITS  = DATA_W + 1;
    localparam int CNT_W = $clog2(OS_NORM);
    localparam int IDX_W = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] LAST_N = CNT_W'(OS_NORM - 1);
    localparam logic [CNT_W-1:0] LAST_F = CNT_W'(OS_FAST - 1);
    localparam logic [CNT_W-1:0] MID_NM = CNT_W'(OS_NORM / 2 - 1);
    localparam logic [CNT_W-1:0] MID_NP = CNT_W'(OS_NORM / 2 + 1);
    localparam logic [CNT_W-1:0] MID_F  = CNT_W'(OS_FAST / 2);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BITS - 1);

    rx_state_t        state, nxt;
    logic [CNT_W-1:0] cnt, last_c;
    logic [IDX_W-1:0] idx;
    logic [2:0]       votes, newv;
    logic [BITS-1:0]  sh;
    logic             take, dec, bitv, at_end;

    // sample window and bit decision
    always_comb begin
        last_c = fast ? LAST_F : LAST_N;
        at_end = (cnt == last_c);
        newv   = {votes[1:0], rx_s};
        if (fast) begin
            take = (cnt == MID_F);
            dec  = take;
            bitv = rx_s;
        end else begin
            take = (cnt >= MID_NM) && (cnt <= MID_NP);
            dec  = (cnt == MID_NP);
            bitv = (newv[0] & newv[1]) | (newv[0] & newv[2]) | (newv[1] & newv[2]);
        end
    end

    always_comb begin
        nxt = state;
        if (tick) begin
            unique case (state)
                S_IDLE:  if (!rx_s) nxt = S_START;
                S_START: if (dec && bitv) nxt = S_IDLE;
                         else if (at_end) nxt = S_SHIFT;
                S_SHIFT: if (at_end && idx == IDX_LAST) nxt = S_STOP;
                S_STOP:  if (dec) nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
        if (!enable) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            idx         <= '0;
            votes       <= 3'b111;
            sh          <= '0;
            frm_done    <= 1'b0;
            frm_stop_ok <= 1'b0;
        end else begin
            frm_done <= 1'b0;
            if (!enable) begin
                cnt <= '0;
                idx <= '0;
            end else if (tick) begin
                if (state == S_IDLE) begin
                    cnt <= CNT_W'(1);
                    idx <= '0;
                end else begin
                    cnt <= at_end ? '0 : cnt + CNT_W'(1);
                    if (take) votes <= newv;
                    if (state == S_SHIFT && dec) sh <= {bitv, sh[BITS-1:1]};
                    if (state == S_SHIFT && at_end) idx <= idx + IDX_W'(1);
                    if (state == S_STOP && dec) begin
                        frm_done    <= 1'b1;
                        frm_stop_ok <= bitv;
                    end
                end
            end
        end
    end

    assign frm_data = sh[DATA_W-1:0];
    assign frm_x    = sh[BITS-1];

    p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state == S_IDLE);
    p_done_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> $past(state) == S_STOP);
    p_stop_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP && $past(state) != S_STOP) |-> $past(state) == S_SHIFT);
    p_false_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state == S_START && dec && bitv) |=> state == S_IDLE && !frm_done);
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mp_mode,
    input  logic              rd_ack,
    input  logic              frm_done,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_x,
    input  logic              frm_stop_ok,
    output logic [DATA_W-1:0] data_q,
    output logic              bit9_q,
    output logic              ready_q,
    output logic              ferr_q,
    output logic              ovr_q
);
    logic accept;
    assign accept = frm_done && !(mp_mode && !frm_x);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || !enable) begin
            data_q  <= '0;
            bit9_q  <= 1'b0;
            ready_q <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (rd_ack) begin
                ready_q <= 1'b0;
                ferr_q  <= 1'b0;
                ovr_q   <= 1'b0;
            end
            if (accept) begin
                if (ready_q && !rd_ack) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q  <= frm_data;
                    bit9_q  <= frm_x;
                    ferr_q  <= !frm_stop_ok;
                    ready_q <= 1'b1;
                end
            end
        end
    end

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !ready_q && !ferr_q && !ovr_q && data_q == '0);
    p_mp_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frm_done && mp_mode && !frm_x && !ready_q && !rd_ack) |=> !ready_q);
    p_keep_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && accept && ready_q && !rd_ack) |=> ovr_q && ready_q && $stable(data_q));
    p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rd_ack && !frm_done) |=> !ready_q && !ferr_q && !ovr_q);
endmodule

// File: rtl/uart_rx_mp.sv
module uart_rx_mp #(
    parameter int DATA_W  = 8,
    parameter int OS_NORM = 16,
    parameter int OS_FAST = 8,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              dbl_speed,
    input  logic              mp_mode,
    input  logic              rxc_ie,
    input  logic              glb_ie,
    input  logic              smp_tick,
    input  logic              rxd,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              frame_err,
    output logic              overrun,
    output logic              irq
);
    logic [SYNC_N-1:0] sync_q;
    logic              f_done, f_x, f_stop;
    logic [DATA_W-1:0] f_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_N-2:0], rxd};
    end

    uart_rx_fsm #(.DATA_W(DATA_W), .OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(rx_en), .fast(dbl_speed),
        .tick(smp_tick), .rx_s(sync_q[SYNC_N-1]),
        .frm_done(f_done), .frm_data(f_data), .frm_x(f_x), .frm_stop_ok(f_stop)
    );

    uart_rx_buf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .enable(rx_en), .mp_mode(mp_mode),
        .rd_ack(rd_ack), .frm_done(f_done), .frm_data(f_data), .frm_x(f_x),
        .frm_stop_ok(f_stop), .data_q(rx_data), .bit9_q(rx_bit9),
        .ready_q(rx_done), .ferr_q(frame_err), .ovr_q(overrun)
    );

    assign irq = rx_done & rxc_ie & glb_ie;
endmodule

// File: tb/tb_uart_rx_mp.sv
`timescale 1ns/1ps
module tb_uart_rx_mp;
    logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, dbl_speed = 1'b0, mp_mode = 1'b0;
    logic rxc_ie = 1'b0, glb_ie = 1'b0, smp_tick = 1'b0, rxd = 1'b1, rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic rx_bit9, rx_done, frame_err, overrun, irq;

    int checks = 0, errors = 0;
    bit chk_on = 1'b0;
    logic [7:0] exp_data = 8'h00;
    logic exp_b9 = 1'b0, exp_rxc = 1'b0, exp_fe = 1'b0, exp_ov = 1'b0;

    uart_rx_mp dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_speed(dbl_speed),
        .mp_mode(mp_mode), .rxc_ie(rxc_ie), .glb_ie(glb_ie), .smp_tick(smp_tick),
        .rxd(rxd), .rd_ack(rd_ack), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_done(rx_done), .frame_err(frame_err), .overrun(overrun), .irq(irq)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            smp_tick = 1'b1;
            @(negedge clk);
            smp_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2 rx_data", rx_data, exp_data);
            chk("R2 rx_bit9", rx_bit9, exp_b9);
            chk("R2 rx_done", rx_done, exp_rxc);
            chk("R6 frame_err", frame_err, exp_fe);
            chk("R7 overrun", overrun, exp_ov);
            chk("R11 irq", irq, exp_rxc & rxc_ie & glb_ie);
        end
    end

    task automatic next_tick;
        do @(posedge clk); while (smp_tick !== 1'b1);
    endtask

    task automatic idle_ticks(input int n);
        rxd = 1'b1;
        repeat (n) next_tick;
        @(negedge clk);
    endtask

    // frame: start, d0..d7, ninth, stop; optional one-sample glitch
    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp,
                              input int os, input int gbit, input int gidx, input bit quiet);
        if (!quiet) chk_on = 1'b0;
        next_tick;
        @(negedge clk);
        for (int b = 0; b < 11; b++) begin
            logic v;
            v = (b == 0) ? 1'b0 : (b <= 8) ? d[b-1] : (b == 9) ? b9 : stp;
            for (int i = 0; i < os; i++) begin
                rxd = (b == gbit && i == gidx) ? ~v : v;
                next_tick;
                @(negedge clk);
            end
        end
        idle_ticks(24);
        if (rx_en && !(mp_mode && !b9)) begin
            if (exp_rxc) exp_ov = 1'b1;
            else begin
                exp_data = d; exp_b9 = b9; exp_fe = !stp; exp_rxc = 1'b1;
            end
        end
        chk_on = 1'b1;
    endtask

    task automatic ack;
        chk_on = 1'b0;
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
        @(negedge clk);
        exp_rxc = 1'b0; exp_fe = 1'b0; exp_ov = 1'b0;
        chk_on = 1'b1;
    endtask

    task automatic set_ctl(input logic en, input logic dbl, input logic mp,
                           input logic rie, input logic gie);
        chk_on = 1'b0;
        @(negedge clk);
        rx_en = en; dbl_speed = dbl; mp_mode = mp; rxc_ie = rie; glb_ie = gie;
        @(negedge clk);
        @(negedge clk);
        if (!en) begin
            exp_data = 8'h00; exp_b9 = 1'b0; exp_rxc = 1'b0; exp_fe = 1'b0; exp_ov = 1'b0;
        end
        chk_on = 1'b1;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rx_data", rx_data, 0);
        chk("R1 rx_bit9", rx_bit9, 0);
        chk("R1 rx_done", rx_done, 0);
        chk("R1 frame_err", frame_err, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 irq", irq, 0);
        chk_on = 1'b1;

        set_ctl(1, 0, 0, 0, 0);
        send_frame(8'hA5, 1, 1, 16, -1, -1, 0);
        chk("R2 data A5", rx_data, 8'hA5);
        chk("R2 ninth", rx_bit9, 1);
        chk("R2 done", rx_done, 1);

        set_ctl(1, 0, 0, 1, 0);
        chk("R11 irq gated by global", irq, 0);
        set_ctl(1, 0, 0, 1, 1);
        chk("R11 irq raised", irq, 1);

        ack();
        chk("R9 done cleared", rx_done, 0);
        chk("R11 irq dropped", irq, 0);

        send_frame(8'h3C, 0, 1, 16, 4, 8, 0);
        chk("R4 majority data", rx_data, 8'h3C);
        chk("R4 ninth 0", rx_bit9, 0);

        send_frame(8'h11, 1, 1, 16, -1, -1, 0);
        chk("R7 overrun set", overrun, 1);
        chk("R7 old byte kept", rx_data, 8'h3C);
        chk("R7 old ninth kept", rx_bit9, 0);
        ack();
        chk("R9 overrun cleared", overrun, 0);

        send_frame(8'h81, 1, 0, 16, -1, -1, 0);
        chk("R6 frame_err", frame_err, 1);
        chk("R6 data", rx_data, 8'h81);
        ack();
        chk("R9 frame_err cleared", frame_err, 0);

        // false start: line low only briefly
        next_tick;
        @(negedge clk);
        rxd = 1'b0;
        repeat (5) next_tick;
        @(negedge clk);
        idle_ticks(24);
        chk("R5 no word after false start", rx_done, 0);
        send_frame(8'h5A, 0, 1, 16, -1, -1, 0);
        chk("R5 recovery data", rx_data, 8'h5A);
        ack();

        set_ctl(1, 1, 0, 1, 1);
        send_frame(8'h96, 1, 1, 8, -1, -1, 0);
        chk("R3 fast data", rx_data, 8'h96);
        chk("R3 fast ninth", rx_bit9, 1);
        ack();
        set_ctl(1, 0, 1, 1, 1);

        send_frame(8'h24, 0, 1, 16, -1, -1, 1);
        chk("R8 data frame dropped", rx_done, 0);
        send_frame(8'h42, 1, 1, 16, -1, -1, 0);
        chk("R8 address frame kept", rx_data, 8'h42);
        send_frame(8'h99, 0, 1, 16, -1, -1, 1);
        chk("R8 drop sets no overrun", overrun, 0);
        chk("R8 held byte intact", rx_data, 8'h42);
        ack();
        set_ctl(1, 0, 0, 1, 1);

        send_frame(8'h77, 1, 1, 16, -1, -1, 0);
        chk("R10 before flush", rx_done, 1);
        set_ctl(0, 0, 0, 1, 1);
        chk("R10 flush done", rx_done, 0);
        chk("R10 flush data", rx_data, 0);
        chk("R10 irq after flush", irq, 0);
        send_frame(8'hEE, 1, 1, 16, -1, -1, 1);
        chk("R10 line ignored", rx_done, 0);
        set_ctl(1, 0, 0, 1, 1);
        send_frame(8'h0F, 1, 1, 16, -1, -1, 0);
        chk("R10 works after re-enable", rx_data, 8'h0F);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule